// File: doc/BRIEF.md
# Bit-Serial Stack Adder/Subtractor

This block holds a last-in-first-out stack of eight 16-bit words and performs addition or subtraction on its two topmost words, the top word and the word under it. The arithmetic is bit-serial. A single full adder with a carry flip-flop processes one bit pair per clock, starting with the least significant bit and ending with the most significant bit. Each sum bit enters the top word at its most significant end while the top word shifts right. After sixteen steps the top word holds the full result in normal bit order.

Subtraction uses the same adder. The carry flip-flop is preset to one and the second operand passes through an inverter, so the result is top minus second. On the final bit step the stack also pops by one place. The third word becomes the second word, each deeper word moves up one place, and the bottom word is filled with zero. The carry left after the last step is kept as a carry/borrow status.

Software or a sequencer loads operands with a push strobe, issues an operation with a start strobe, waits for the done pulse, and reads the top word and the carry.

Top module: `ser_stack_alu`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o` and `carry_o` are 0, `tos_o` is 0, and every stack entry is 0.
- R2: When `busy_o` is 0 and `start_i` is 0, a high `push_i` loads `push_data_i` into the top word on the next clock. Every other entry moves one place deeper and the bottom entry is lost. While `busy_o` is 1, `push_i` is ignored.
- R3: A `start_i` seen while `busy_o` is 0 makes `busy_o` rise on the next clock. `busy_o` then stays high for exactly 16 cycles, one per bit. `done_o` is high for exactly one cycle, the cycle right after the last busy cycle, while `busy_o` is low. A `start_i` seen while `busy_o` is 1 is ignored.
- R4: With `op_sub_i`=0 at the start (add), the top word becomes (top + second) mod 2^16. `carry_o` becomes the carry out of bit 15.
- R5: With `op_sub_i`=1 at the start (subtract), the top word becomes (top − second) mod 2^16. `carry_o` becomes 1 when top ≥ second, compared as unsigned numbers (no borrow), and 0 otherwise.
- R6: When an operation completes, the stack pops. Entry k takes the old entry k+1 for k = 1..6, and entry 7 (the bottom) becomes 0.
- R7: `carry_o` changes only on the clock that ends the final bit step. At all other times it holds its value, including while an operation runs.
- R8: `op_sub_i` is sampled only together with an accepted start. Changing it while `busy_o` is 1 has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for an arithmetic operation |
| op_sub_i | input | 1 | Operation select: 0 = add, 1 = subtract |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 16 | Value pushed into the top word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry (add) or no-borrow (subtract) of the last operation |
| tos_o | output | 16 | Current top-of-stack word |

## Verification
Only the top word is visible, so the pop and the zero fill of the bottom entry are the hardest behaviour to observe. To reach it, the bench pushes eight distinct values so that the bottom entry holds real data, then runs seven additions in a row. A correct design then has zero in the second place. If the bottom entry were kept instead of cleared, the eighth addition would add back the first pushed value, and the top word would differ. Disturbances on `start_i`, `op_sub_i` and `push_i` are injected in the middle of a running operation to show that they are ignored.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
        fa_out_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (a & cin) | (b & cin);
        return r;
    endfunction

endpackage

// File: rtl/ssa_bit_seq.sv
module ssa_bit_seq
    import ssa_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic op_sub_i,
    output logic accept_o,
    output logic step_o,
    output logic last_o,
    output logic sub_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STEPS - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sub_q;
    logic              done_q;

    assign accept_o = start_i && (state_q == SEQ_IDLE);
    assign step_o   = (state_q == SEQ_RUN);
    assign last_o   = step_o && (cnt_q == '0);
    assign sub_o    = sub_q;
    assign busy_o   = step_o;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            sub_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                state_q <= SEQ_RUN;
                cnt_q   <= CNT_TOP;
                sub_q   <= op_sub_i;
            end else if (last_o) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
            end else if (step_o) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssa_serial_adder.sv
module ssa_serial_adder
    import ssa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic preset_i,
    input  logic preset_val_i,
    input  logic step_i,
    input  logic last_i,
    input  logic invert_b_i,
    input  logic a_bit_i,
    input  logic b_bit_i,
    output logic sum_bit_o,
    output logic carry_stat_o
);
    logic    carry_q;
    logic    stat_q;
    fa_out_t fa;

    always_comb begin
        fa = full_add(a_bit_i, b_bit_i ^ invert_b_i, carry_q);
    end

    assign sum_bit_o    = fa.sum;
    assign carry_stat_o = stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            stat_q  <= 1'b0;
        end else begin
            if (preset_i) begin
                carry_q <= preset_val_i;
            end else if (step_i) begin
                carry_q <= fa.carry;
            end
            if (last_i) begin
                stat_q <= fa.carry;
            end
        end
    end
endmodule

// File: rtl/ssa_reg_stack.sv
module ssa_reg_stack #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             step_i,
    input  logic             last_i,
    input  logic             sum_bit_i,
    output logic [WIDTH-1:0] top_o,
    output logic             top_lsb_o,
    output logic             sec_lsb_o
);
    logic [WIDTH-1:0] ent_q [DEPTH];

    assign top_o     = ent_q[0];
    assign top_lsb_o = ent_q[0][0];
    assign sec_lsb_o = ent_q[1][0];

    // Top entry: shifts right with each new sum bit entering at the MSB.
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q[0] <= '0;
        end else if (push_i) begin
            ent_q[0] <= push_data_i;
        end else if (step_i) begin
            ent_q[0] <= {sum_bit_i, ent_q[0][WIDTH-1:1]};
        end
    end

    // Second entry: shifts right in step; refilled from the third on the pop.
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q[1] <= '0;
        end else if (push_i) begin
            ent_q[1] <= ent_q[0];
        end else if (last_i) begin
            ent_q[1] <= (DEPTH > 2) ? ent_q[2 % DEPTH] : '0;
        end else if (step_i) begin
            ent_q[1] <= {1'b0, ent_q[1][WIDTH-1:1]};
        end
    end

    // Deeper entries: push moves them down, the pop moves them up, bottom gets zero.
    for (genvar g = 2; g < DEPTH; g++) begin : g_deep
        logic [WIDTH-1:0] below;
        if (g == DEPTH - 1) begin : g_bottom
            assign below = '0;
        end else begin : g_mid
            assign below = ent_q[g + 1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (push_i) begin
                ent_q[g] <= ent_q[g - 1];
            end else if (last_i) begin
                ent_q[g] <= below;
            end
        end
    end
endmodule

// File: rtl/ser_stack_alu.sv
module ser_stack_alu #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             op_sub_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             carry_o,
    output logic [WIDTH-1:0] tos_o
);
    logic accept, step, last, sub_sel;
    logic top_lsb, sec_lsb, sum_bit;
    logic push_ok;

    assign push_ok = push_i && !busy_o && !start_i;

    ssa_bit_seq #(.STEPS(WIDTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_sub_i (op_sub_i),
        .accept_o (accept),
        .step_o   (step),
        .last_o   (last),
        .sub_o    (sub_sel),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    ssa_serial_adder u_add (
        .clk          (clk),
        .rst          (rst),
        .preset_i     (accept),
        .preset_val_i (op_sub_i),
        .step_i       (step),
        .last_i       (last),
        .invert_b_i   (sub_sel),
        .a_bit_i      (top_lsb),
        .b_bit_i      (sec_lsb),
        .sum_bit_o    (sum_bit),
        .carry_stat_o (carry_o)
    );

    ssa_reg_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_ok),
        .push_data_i (push_data_i),
        .step_i      (step),
        .last_i      (last),
        .sum_bit_i   (sum_bit),
        .top_o       (tos_o),
        .top_lsb_o   (top_lsb),
        .sec_lsb_o   (sec_lsb)
    );
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             push_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             carry_o,
    input logic [WIDTH-1:0] tos_o
);
    logic [$clog2(WIDTH+2)-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !carry_o && tos_o == '0));

    a_r2_push_loads: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && push_i) |=> (tos_o == $past(push_data_i)));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !push_i) |=> $stable(tos_o));

    a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_len == WIDTH));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r7_carry_held: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(carry_o));
endmodule

bind ser_stack_alu ssa_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .carry_o     (carry_o),
    .tos_o       (tos_o)
);

// File: tb/ser_stack_alu_tb_top.sv
`timescale 1ns/1ps
module ser_stack_alu_tb_top;
    localparam int W = 16;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         op_sub_i = 1'b0;
    logic         push_i = 1'b0;
    logic [W-1:0] push_data_i = '0;
    logic         busy_o, done_o, carry_o;
    logic [W-1:0] tos_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] model [D];
    logic         model_carry;

    always #4 clk = ~clk;

    ser_stack_alu #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_sub_i(op_sub_i),
        .push_i(push_i), .push_data_i(push_data_i),
        .busy_o(busy_o), .done_o(done_o), .carry_o(carry_o), .tos_o(tos_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < D; i++) model[i] = '0;
        model_carry = 1'b0;
    endtask

    task automatic do_push(input logic [W-1:0] v);
        @(negedge clk);
        push_i = 1'b1;
        push_data_i = v;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0;
        for (int i = D - 1; i > 0; i--) model[i] = model[i-1];
        model[0] = v;
        check("R2", "tos after push", tos_o, v);
    endtask

    // Runs one operation; disturb injects start, push and an op flip mid-run.
    task automatic do_op(input logic sub, input bit disturb, input string req);
        logic [W:0] full;
        @(negedge clk);
        start_i = 1'b1;
        op_sub_i = sub;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R3", "busy after start", busy_o, 1'b1);
        for (int i = 1; i < W; i++) begin
            if (disturb && i == 5) begin
                start_i = 1'b1;
                push_i = 1'b1;
                push_data_i = 16'hDEAD;
                op_sub_i = ~sub;
            end else begin
                start_i = 1'b0;
                push_i = 1'b0;
                op_sub_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            if (i == W - 1 || disturb) check("R3", "busy held", busy_o, 1'b1);
        end
        start_i = 1'b0;
        push_i = 1'b0;
        op_sub_i = 1'b0;
        if (sub) full = {1'b0, model[0]} + {1'b0, ~model[1]} + 17'd1;
        else     full = {1'b0, model[0]} + {1'b0, model[1]};
        model[0] = full[W-1:0];
        model_carry = full[W];
        for (int i = 1; i < D - 1; i++) model[i] = model[i+1];
        model[D-1] = '0;
        @(posedge clk);
        @(negedge clk);
        check("R3", "busy low at end", busy_o, 1'b0);
        check("R3", "done pulse", done_o, 1'b1);
        check(req, "result", tos_o, model[0]);
        check(req, "carry", carry_o, model_carry);
        @(posedge clk);
        @(negedge clk);
        check("R3", "done single", done_o, 1'b0);
        check("R7", "carry held idle", carry_o, model_carry);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "busy", busy_o, 1'b0);
        check("R1", "done", done_o, 1'b0);
        check("R1", "carry", carry_o, 1'b0);
        check("R1", "tos", tos_o, '0);
        do_op(1'b0, 1'b0, "R1");
    endtask

    task automatic t_add();
        do_reset();
        do_push(16'h4321); do_push(16'h1234);
        do_op(1'b0, 1'b0, "R4");
        do_push(16'h0001); do_push(16'hFFFF);
        do_op(1'b0, 1'b0, "R4");
        do_push(16'h8000); do_push(16'h8001);
        do_op(1'b0, 1'b0, "R4");
    endtask

    task automatic t_sub();
        do_reset();
        do_push(16'h0003); do_push(16'h0005);
        do_op(1'b1, 1'b0, "R5");
        do_push(16'h0005); do_push(16'h0003);
        do_op(1'b1, 1'b0, "R5");
        do_push(16'hA5A5); do_push(16'hA5A5);
        do_op(1'b1, 1'b0, "R5");
    endtask

    task automatic t_disturb();
        do_reset();
        do_push(16'h0100); do_push(16'h0F0F);
        do_op(1'b0, 1'b1, "R8");
        do_push(16'h7000); do_push(16'h1000);
        do_op(1'b1, 1'b1, "R2");
        check("R7", "carry after sub", carry_o, 1'b0);
    endtask

    task automatic t_pop();
        do_reset();
        for (int i = 0; i < D; i++) do_push(W'(16'h0011 * (i + 1)));
        for (int i = 0; i < D; i++) do_op(1'b0, 1'b0, "R6");
        do_push(16'h2222); do_push(16'h3333);
        do_op(1'b1, 1'b0, "R6");
        do_op(1'b0, 1'b0, "R6");
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_disturb();
        t_pop();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule